// File: doc/BRIEF.md
# UART Modem Status and Interrupt Priority

This block holds the modem-side control and status of one UART channel, together with its interrupt enables and its interrupt identification logic. It takes four active-low modem inputs (clear-to-send, data-set-ready, ring, carrier detect), passes them through synchronisers and flags changes on them. It drives two active-low modem outputs and two auxiliary active-low outputs from a host-written control register. It merges four interrupt sources into one prioritised code and one interrupt line. Those sources are line errors, received data, transmit holding register empty and modem status change.

A host reaches the block through a 3-bit address with read and write strobes. Reads of the line status register and of the receive buffer are decoded at the same addresses a full UART uses, but the line error and data-ready flags are levels owned by the neighbouring receiver. The block only ranks them. A local loopback mode feeds the control bits back into the status bits and exports a loop flag for the serial data path.

Top module: `modem_irq_ctrl`

## Requirements
- R1: After reset the interrupt enables, the control register and the four change flags read 0. All four modem outputs are high, `irq` is low and the identification register (address 2) reads 0x01.
- R2: The interrupt enable register at address 1 stores bits 3:0 and reads 0 in bits 7:4. The control register at address 4 stores bits 4:0 (0 data-terminal-ready, 1 request-to-send, 2 aux1, 3 aux2, 4 loop) and reads 0 in bits 7:5.
- R3: Outside loop mode, `dtr_n`, `rts_n`, `aux1_n` and `aux2_n` are the complements of control bits 0, 1, 2 and 3.
- R4: Outside loop mode, status register (address 6) bits 4, 5, 6 and 7 are the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, after SYNC_STAGES cycles of synchronisation.
- R5: Status bits 0, 1 and 3 set on any change of clear-to-send, data-set-ready and carrier detect. Bit 2 sets only when `ri_n` goes from low to high. A set flag holds until the status register is read.
- R6: A read of the status register clears all four change flags. A change that arrives in the same cycle as that read leaves its flag set.
- R7: With control bit 4 set, `loop_en` is high and all four modem outputs are high. Status bits 4 to 7 show control bits 1, 0, 2 and 3 in that order, change flags follow those values, and the external modem inputs have no effect.
- R8: The identification register reads 0x06 for line error, 0x04 for data ready, 0x02 for holding register empty, 0x00 for modem change and 0x01 for none, in that priority. A source counts only when its enable bit is set (bit 2 line, 0 data, 1 holding register, 3 modem).
- R9: The holding-register-empty interrupt sets when `thr_empty` and enable bit 1 become true together. It clears on a write to address 0, or on an identification read that reports 0x02. An identification read that reports a higher source leaves it pending.
- R10: `irq` is high exactly when control bit 3 is set and the identification code is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| line_err | input | 4 | Receiver error flags (any set raises the line source) |
| rx_ready | input | 1 | Receiver data-ready level |
| thr_empty | input | 1 | Transmit holding register empty level |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| aux1_n | output | 1 | Auxiliary output 1, active low |
| aux2_n | output | 1 | Auxiliary output 2, active low |
| loop_en | output | 1 | Loopback flag for the serial data path |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the ring flag, which must ignore the leading edge. A design that used a plain change detector would report a ring on the falling input as well. It holds a status read exactly across the cycle in which a synchronised change lands; a design that let the clear win would lose that change for good. It checks that an identification read reporting a higher source leaves the holding-register-empty interrupt pending, since clearing it on any such read would drop an interrupt. It also checks that loop mode swaps the status sources, raises every modem output and hides external toggles. Randomly timed modem changes with and without intervening reads test that flags accumulate.

// File: rtl/modem_irq_pkg.sv
package modem_irq_pkg;
  localparam int AW = 3;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_DATA = 3'd0;
  localparam logic [AW-1:0] A_IEN  = 3'd1;
  localparam logic [AW-1:0] A_IID  = 3'd2;
  localparam logic [AW-1:0] A_MCTL = 3'd4;
  localparam logic [AW-1:0] A_LST  = 3'd5;
  localparam logic [AW-1:0] A_MST  = 3'd6;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_NONE  = 3'b001,
    ID_THRE  = 3'b010,
    ID_RXD   = 3'b100,
    ID_LINE  = 3'b110
  } irq_id_e;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= d;
        else stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pins_n,   // {dcd, ri, dsr, cts}
  input  logic       loop,
  input  logic [3:0] ctl,      // {aux2, aux1, dtr, rts}
  input  logic       clr,
  output logic [7:0] status,
  output logic [3:0] chg,
  output logic [3:0] delta
);
  logic [3:0] sync_n;
  logic [3:0] live;
  logic [3:0] prev_q;
  logic [3:0] delta_q, delta_d;

  mdm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(sync_n)
  );

  always_comb begin
    live    = loop ? ctl : ~sync_n;
    chg[0]  = live[0] ^ prev_q[0];
    chg[1]  = live[1] ^ prev_q[1];
    chg[2]  = prev_q[2] & ~live[2];   // ring: trailing edge only
    chg[3]  = live[3] ^ prev_q[3];
    delta_d = (clr ? 4'b0 : delta_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= live;
      delta_q <= delta_d;
    end
  end

  assign status = {live, delta_q};
  assign delta  = delta_q;
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import modem_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ien,
  input  logic       line_any,
  input  logic       rx_ready,
  input  logic       thr_empty,
  input  logic       modem_any,
  input  logic       thr_wr,
  input  logic       iid_rd,
  output irq_id_e    iid,
  output logic       pending,
  output logic       thre_pend
);
  logic thre_cond, cond_q;
  logic thre_q, thre_d;
  logic thre_set, thre_clr;

  always_comb begin
    thre_cond = thr_empty & ien[1];
    thre_set  = thre_cond & ~cond_q;
    thre_clr  = thr_wr | (iid_rd & (iid == ID_THRE));
    if (thre_set)      thre_d = 1'b1;
    else if (thre_clr) thre_d = 1'b0;
    else               thre_d = thre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      cond_q <= thre_cond;
      thre_q <= thre_d;
    end
  end

  always_comb begin
    if (ien[2] & line_any)       iid = ID_LINE;
    else if (ien[0] & rx_ready)  iid = ID_RXD;
    else if (ien[1] & thre_q)    iid = ID_THRE;
    else if (ien[3] & modem_any) iid = ID_MODEM;
    else                         iid = ID_NONE;
  end

  assign pending   = (iid != ID_NONE);
  assign thre_pend = thre_q;
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
  import modem_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          ri_n,
  input  logic          dcd_n,
  input  logic [3:0]    line_err,
  input  logic          rx_ready,
  input  logic          thr_empty,
  output logic          rts_n,
  output logic          dtr_n,
  output logic          aux1_n,
  output logic          aux2_n,
  output logic          loop_en,
  output logic          irq
);
  logic [3:0] ien_q, ien_d;
  logic [4:0] mctl_q, mctl_d;
  logic       ien_we, mctl_we;
  logic [7:0] mst;
  logic [3:0] chg_w, delta_w;
  logic       thre_w, pending;
  irq_id_e    iid;

  always_comb begin
    ien_we  = wr_en & (addr == A_IEN);
    mctl_we = wr_en & (addr == A_MCTL);
    ien_d   = ien_we  ? wdata[3:0] : ien_q;
    mctl_d  = mctl_we ? wdata[4:0] : mctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      mctl_q <= '0;
    end else begin
      ien_q  <= ien_d;
      mctl_q <= mctl_d;
    end
  end

  mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .pins_n({dcd_n, ri_n, dsr_n, cts_n}),
    .loop(mctl_q[4]),
    .ctl({mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1]}),
    .clr(rd_en & (addr == A_MST)),
    .status(mst), .chg(chg_w), .delta(delta_w)
  );

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .ien(ien_q),
    .line_any(|line_err), .rx_ready(rx_ready), .thr_empty(thr_empty),
    .modem_any(|delta_w),
    .thr_wr(wr_en & (addr == A_DATA)),
    .iid_rd(rd_en & (addr == A_IID)),
    .iid(iid), .pending(pending), .thre_pend(thre_w)
  );

  always_comb begin
    case (addr)
      A_IEN:   rdata = {4'b0, ien_q};
      A_IID:   rdata = {5'b0, iid};
      A_MCTL:  rdata = {3'b0, mctl_q};
      A_MST:   rdata = mst;
      default: rdata = '0;
    endcase
  end

  assign loop_en = mctl_q[4];
  assign dtr_n   = ~(mctl_q[0] & ~mctl_q[4]);
  assign rts_n   = ~(mctl_q[1] & ~mctl_q[4]);
  assign aux1_n  = ~(mctl_q[2] & ~mctl_q[4]);
  assign aux2_n  = ~(mctl_q[3] & ~mctl_q[4]);
  assign irq     = mctl_q[3] & pending;
endmodule

// File: rtl/modem_irq_chk.sv
module modem_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       aux1_n,
  input logic       aux2_n,
  input logic       loop_en,
  input logic       irq,
  input logic [3:0] chg_w,
  input logic [3:0] delta_w
);
  AST_LOOP_OUTPUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rts_n && dtr_n && aux1_n && aux2_n)); // R7

  AST_IRQ_NEEDS_AUX2: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && aux2_n) |-> !irq); // R10

  AST_IEN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd1) |-> (rdata[7:4] == 4'b0)); // R2

  AST_IID_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2) |-> (rdata == 8'h01 || rdata == 8'h06 || rdata == 8'h04 ||
                        rdata == 8'h02 || rdata == 8'h00)); // R8

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd6 && chg_w == 4'b0) |=> (delta_w == 4'b0)); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == 3'd6) |=> ((delta_w & $past(delta_w)) == $past(delta_w))); // R5
endmodule

bind modem_irq_ctrl modem_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
  .rts_n(rts_n), .dtr_n(dtr_n), .aux1_n(aux1_n), .aux2_n(aux2_n),
  .loop_en(loop_en), .irq(irq), .chg_w(chg_w), .delta_w(delta_w)
);

// File: tb/sim_modem_irq_ctrl.sv
`timescale 1ns/1ps
module sim_modem_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic [3:0] line_err;
  logic       rx_ready, thr_empty;
  logic       rts_n, dtr_n, aux1_n, aux2_n, loop_en, irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  modem_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .line_err(line_err), .rx_ready(rx_ready),
    .thr_empty(thr_empty), .rts_n(rts_n), .dtr_n(dtr_n), .aux1_n(aux1_n),
    .aux2_n(aux2_n), .loop_en(loop_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic done();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #5 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] mctl_pins(input logic [7:0] v);
    logic lp;
    lp = v[4];
    return {4'b0, ~(v[3] & ~lp), ~(v[2] & ~lp), ~(v[1] & ~lp), ~(v[0] & ~lp)};
  endfunction

  function automatic logic [3:0] flag_update(input logic [3:0] oldn, input logic [3:0] newn);
    // index 0 cts, 1 dsr, 2 ri, 3 dcd (active-low pin values)
    return {oldn[3] ^ newn[3], ~oldn[2] & newn[2], oldn[1] ^ newn[1], oldn[0] ^ newn[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    logic [7:0] v;
    logic [3:0] prevn, newn, dexp;
    void'($urandom(32'd4242));
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1;
    line_err = '0; rx_ready = 0; thr_empty = 1;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 pins", {4'b0, aux2_n, aux1_n, rts_n, dtr_n}, 8'h0F);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(3'd2, v); chk("R1 iid", v, 8'h01);
    rd(3'd1, v); chk("R1 ien", v, 8'h00);
    rd(3'd4, v); chk("R1 mctl", v, 8'h00);
    rd(3'd6, v); chk("R1 mst", v, 8'h00);

    // R9 holding register empty: set by enable, cleared by id read
    wr(3'd1, 8'hF2);
    rd(3'd1, v); chk("R2 ien readback", v, 8'h02);
    chk("R10 irq gated off", {7'b0, irq}, 8'h00);
    wr(3'd4, 8'h08);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    rd(3'd2, v); chk("R8 thre code", v, 8'h02);
    rd(3'd2, v); chk("R9 cleared by id read", v, 8'h01);
    chk("R10 irq off after clear", {7'b0, irq}, 8'h00);

    // R9 write to address 0 clears
    thr_empty = 0; idle(1); thr_empty = 1; idle(2);
    chk("R9 re-armed irq", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h55);
    rd(3'd2, v); chk("R9 cleared by data write", v, 8'h01);

    // R8 priority, R9 not cleared by higher-source read
    thr_empty = 0; idle(1); thr_empty = 1; idle(2);
    rx_ready = 1;
    wr(3'd1, 8'h03);
    rd(3'd2, v); chk("R8 data over thre", v, 8'h04);
    rd(3'd2, v); chk("R9 thre kept under data", v, 8'h04);
    rx_ready = 0; idle(1);
    rd(3'd2, v); chk("R9 thre still pending", v, 8'h02);
    thr_empty = 0; idle(1); thr_empty = 1; idle(2);
    line_err = 4'b0100; rx_ready = 1;
    wr(3'd1, 8'h07);
    rd(3'd2, v); chk("R8 line highest", v, 8'h06);
    line_err = 4'b0; idle(1);
    rd(3'd2, v); chk("R8 data second", v, 8'h04);
    rx_ready = 0; idle(1);
    rd(3'd2, v); chk("R8 thre third", v, 8'h02);
    wr(3'd1, 8'h01);
    rd(3'd2, v); chk("R8 disabled sources", v, 8'h01);

    // R4 R5 R6 modem change
    wr(3'd1, 8'h08);
    cts_n = 0; idle(4);
    rd(3'd2, v); chk("R8 modem code", v, 8'h00);
    chk("R10 irq modem", {7'b0, irq}, 8'h01);
    rd(3'd6, v); chk("R4 R5 cts change", v, 8'h11);
    rd(3'd2, v); chk("R6 cleared by read", v, 8'h01);
    ri_n = 0; idle(4);
    rd(3'd6, v); chk("R5 ring leading ignored", v, 8'h50);
    ri_n = 1; idle(4);
    rd(3'd6, v); chk("R5 ring trailing flag", v, 8'h14);
    dsr_n = 0; dcd_n = 0; idle(4);
    rd(3'd6, v); chk("R5 dsr dcd flags", v, 8'hBA);

    // R6 change landing in the read cycle survives
    cts_n = 1;
    idle(2);
    rd(3'd6, v); chk("R6 read during change", v, 8'hA0);
    rd(3'd6, v); chk("R6 flag kept", v, 8'hA1);
    rd(3'd6, v); chk("R6 cleared after", v, 8'hA0);

    // R7 loopback
    cts_n = 1; dsr_n = 1; ri_n = 1; dcd_n = 1; idle(4);
    rd(3'd6, v);
    wr(3'd4, 8'h1B);
    chk("R7 pins high", {3'b0, loop_en, aux2_n, aux1_n, rts_n, dtr_n}, 8'h1F);
    idle(2);
    rd(3'd6, v);
    rd(3'd6, v); chk("R7 status from control", v, 8'hB0);
    cts_n = 0; ri_n = 0; dsr_n = 0; dcd_n = 0; idle(4);
    rd(3'd6, v); chk("R7 external ignored", v, 8'hB0);
    wr(3'd4, 8'h1C);
    rd(3'd6, v); chk("R7 R5 aux1 rise no flag", v, 8'hC3);
    wr(3'd4, 8'h18);
    chk("R7 R10 irq in loop", {7'b0, irq}, 8'h01);
    rd(3'd6, v); chk("R7 R5 aux1 fall flag", v, 8'h84);
    cts_n = 1; ri_n = 1; dsr_n = 1; dcd_n = 1;
    wr(3'd4, 8'h00); idle(4);
    rd(3'd6, v); rd(3'd6, v); chk("R4 back to pins", v, 8'h00);

    // R4 R5 R6 random modem activity
    wr(3'd1, 8'h00);
    prevn = 4'hF; dexp = 4'h0;
    for (int i = 0; i < 60; i++) begin
      newn = 4'($urandom);
      cts_n = newn[0]; dsr_n = newn[1]; ri_n = newn[2]; dcd_n = newn[3];
      idle(4);
      dexp = dexp | flag_update(prevn, newn);
      prevn = newn;
      if (($urandom % 3) != 0) begin
        rd(3'd6, v);
        chk("R4 R5 random status", v, {~newn, dexp});
        dexp = 4'h0;
      end
    end

    // R2 R3 random register traffic
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr(3'd4, d);
      rd(3'd4, v); chk("R2 mctl readback", v, {3'b0, d[4:0]});
      chk("R3 R7 pins", {4'b0, aux2_n, aux1_n, rts_n, dtr_n}, mctl_pins(d));
      chk("R7 loop flag", {7'b0, loop_en}, {7'b0, d[4]});
      d = 8'($urandom);
      wr(3'd1, d);
      rd(3'd1, v); chk("R2 ien readback", v, {4'b0, d[3:0]});
    end

    done();
  end
endmodule